// File: doc/BRIEF.md
# Instruction Decode Stage with Ordered Pending-Write Scoreboard

This block is the decode step of a simple in-order pipeline. An instruction word enters together with two opcode flags from the fetch side: one marks a store and one marks a no-operation. The block holds the word in a one-entry slot. A 2-bit class code in the low bits of the word selects the class: register, immediate, jump or invalid. From that class the block cuts the rest of the word into two register numbers and a third operand. The third operand is a register number or a sign-extended immediate.

Before the instruction leaves the slot, every register that it reads is compared with a queue of destinations that are still waiting to be written back. If a read register is still waiting, the block raises a stall and keeps the instruction in its slot. If the instruction writes a register, that register number goes onto the tail of the queue when the instruction issues. The writeback side retires entries one at a time from the head of the queue by pulsing a pop input. The queue holds a fixed number of entries. An instruction that needs a queue entry waits while the queue is full.

Top module: `decodeScoreboard`

## Requirements
- R1: The class code is word bits [1:0]: 2'b00 register class, 2'b01 immediate class, 2'b10 jump class, 2'b11 invalid. `decType` shows the code of the held word. An invalid word drives all three operand outputs to zero, checks nothing and reserves nothing.
- R2: Register class: `decS1` = word[6:2], `decS2` = word[11:7], `decS3` = word[16:12], each zero-extended. S1 and S2 are read registers and S3 is the destination.
- R3: Immediate class without the store flag: `decS1` = word[6:2], `decS2` = word[11:7], and `decS3` = word[31:12] sign-extended to 32 bits. S1 is read. S2 is the destination, and it is not checked against the queue.
- R4: Immediate class with the store flag: the fields are the same as in R3. Both S1 and S2 are read, and no destination is reserved.
- R5: Jump class: `decS1` = word[6:2] is read, `decS2` = word[31:7] sign-extended to 32 bits, `decS3` = 0. Nothing is reserved.
- R6: While a read register equals a live queue entry, `stall` is 1, and `decValid` and `inReady` are 0. The held word stays unchanged. The instruction issues in the cycle after the edge that pops the blocking entry.
- R7: The queue is ordered. At the issue edge the destination is appended at the tail, and `pendHead` shows the oldest entry. At each edge with `wbPop` high the head entry is removed. A pop while the queue is empty is ignored. A push and a pop at the same edge leave the count unchanged.
- R8: The queue holds DEPTH entries (default 8). While `pendCount` equals DEPTH, an instruction that needs a destination stalls. An instruction that reserves nothing still issues.
- R9: With the no-operation flag set, the instruction issues without checks. All three operand outputs are zero, `decNop` is 1, and nothing is reserved.
- R10: After reset the slot is empty and the queue is empty: `pendCount` = 0, `stall` = 0, `decValid` = 0 and `inReady` = 1.
- R11: A word accepted at an edge appears on the decode outputs in the following cycle. While the held instruction issues, `inReady` stays 1 so that a new word can be accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Fetch presents a word |
| inWord | input | 32 | Instruction word |
| inStore | input | 1 | Opcode is a store |
| inNop | input | 1 | Opcode is a no-operation |
| inReady | output | 1 | Slot accepts a word at this edge |
| stall | output | 1 | Held instruction is blocked |
| decValid | output | 1 | Held instruction issues this cycle |
| decType | output | 2 | Class code of the held word |
| decNop | output | 1 | Held instruction is a no-operation |
| decS1 | output | 32 | First operand field |
| decS2 | output | 32 | Second operand field |
| decS3 | output | 32 | Third operand field |
| wbPop | input | 1 | Writeback retires the head entry |
| pendHead | output | 5 | Oldest pending destination (valid when the count is nonzero) |
| pendCount | output | 4 | Number of pending destinations |

## Verification
A queue pointer or count that drifts from the true contents shows up at the ports almost at once. `pendHead` names the wrong register after the next pop. An instruction then either stalls against a register that has already retired, or issues past one that is still waiting. Both show on `stall` and `decValid` in the cycle after the instruction is loaded. A wrong field split shows on the operand outputs in the same cycle. A wrong read or reserve set for stores and the other immediate forms shows only when a later instruction touches that register. For this reason the bench pairs each such case with a dependent instruction.

// File: rtl/decodePkg.sv
package decodePkg;

  typedef enum logic [1:0] {
    TY_REG = 2'b00,
    TY_IMM = 2'b01,
    TY_JMP = 2'b10,
    TY_BAD = 2'b11
  } instrClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new word into the slot
    logic issue;  // held instruction leaves the slot
    logic push;   // destination is appended to the pending queue
  } decStrobe_t;

endpackage

// File: rtl/decodeDatapath.sv
module decodeDatapath
  import decodePkg::*;
#(
  parameter int WORD_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inStore,
  input  logic              inNop,
  input  decStrobe_t        strb,
  output logic              curValid,
  output logic              curNop,
  output logic [REG_W-1:0]  srcA,
  output logic [REG_W-1:0]  srcB,
  output logic              useA,
  output logic              useB,
  output logic [REG_W-1:0]  dst,
  output logic              useDst,
  output logic [1:0]        decType,
  output logic [WORD_W-1:0] decS1,
  output logic [WORD_W-1:0] decS2,
  output logic [WORD_W-1:0] decS3
);

  localparam int PAY_W   = WORD_W - 2;
  localparam int IMM_I_W = PAY_W - 2 * REG_W;
  localparam int IMM_J_W = PAY_W - REG_W;

  logic [WORD_W-1:0] curWord;
  logic              curStore;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curValid <= 1'b0;
      curWord  <= '0;
      curStore <= 1'b0;
      curNop   <= 1'b0;
    end else if (strb.load) begin
      curValid <= 1'b1;
      curWord  <= inWord;
      curStore <= inStore;
      curNop   <= inNop;
    end else if (strb.issue) begin
      curValid <= 1'b0;
    end
  end

  logic [PAY_W-1:0]   payload;
  logic [REG_W-1:0]   fieldA, fieldB, fieldC;
  logic [IMM_I_W-1:0] immI;
  logic [IMM_J_W-1:0] immJ;
  instrClass_e        cls;

  assign payload = curWord[WORD_W-1:2];
  assign cls     = instrClass_e'(curWord[1:0]);
  assign fieldA  = payload[REG_W-1:0];
  assign fieldB  = payload[2*REG_W-1:REG_W];
  assign fieldC  = payload[3*REG_W-1:2*REG_W];
  assign immI    = payload[PAY_W-1:2*REG_W];
  assign immJ    = payload[PAY_W-1:REG_W];
  assign decType = curWord[1:0];

  always_comb begin
    decS1  = '0;
    decS2  = '0;
    decS3  = '0;
    srcA   = fieldA;
    srcB   = fieldB;
    useA   = 1'b0;
    useB   = 1'b0;
    dst    = fieldB;
    useDst = 1'b0;
    if (!curNop) begin
      unique case (cls)
        TY_REG: begin
          decS1  = {{(WORD_W-REG_W){1'b0}}, fieldA};
          decS2  = {{(WORD_W-REG_W){1'b0}}, fieldB};
          decS3  = {{(WORD_W-REG_W){1'b0}}, fieldC};
          useA   = 1'b1;
          useB   = 1'b1;
          dst    = fieldC;
          useDst = 1'b1;
        end
        TY_IMM: begin
          decS1  = {{(WORD_W-REG_W){1'b0}}, fieldA};
          decS2  = {{(WORD_W-REG_W){1'b0}}, fieldB};
          decS3  = {{(WORD_W-IMM_I_W){immI[IMM_I_W-1]}}, immI};
          useA   = 1'b1;
          useB   = curStore;
          dst    = fieldB;
          useDst = !curStore;
        end
        TY_JMP: begin
          decS1 = {{(WORD_W-REG_W){1'b0}}, fieldA};
          decS2 = {{(WORD_W-IMM_J_W){immJ[IMM_J_W-1]}}, immJ};
          useA  = 1'b1;
        end
        default: begin
        end
      endcase
    end
  end

  // R6: a blocked instruction stays in the slot untouched
  a_r6_slot_held: assert property (@(posedge clk) disable iff (!rstN)
    (curValid && !strb.issue) |=> (curValid && $stable(curWord) && $stable(curStore)));

  // R11: a load always leaves the slot occupied
  a_r11_load_fills: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> curValid);

endmodule

// File: rtl/decodeControl.sv
module decodeControl
  import decodePkg::*;
#(
  parameter int REG_W = 5,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             wbPop,
  input  logic             curValid,
  input  logic             curNop,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic             useA,
  input  logic             useB,
  input  logic [REG_W-1:0] dst,
  input  logic             useDst,
  output decStrobe_t       strb,
  output logic             stall,
  output logic             inReady,
  output logic [REG_W-1:0] pendHead,
  output logic [$clog2(DEPTH):0] pendCount
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_X = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);

  logic [REG_W-1:0] qMem [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  logic [DEPTH-1:0] hitA, hitB;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [CNT_W-1:0] rawOff, offset;
    logic             live;
    assign rawOff  = CNT_W'(g) + DEPTH_X - {1'b0, head};
    assign offset  = (rawOff >= DEPTH_X) ? rawOff - DEPTH_X : rawOff;
    assign live    = offset < count;
    assign hitA[g] = live && (qMem[g] == srcA);
    assign hitB[g] = live && (qMem[g] == srcB);
  end

  logic queueFull, hazard, popOk;

  assign queueFull = (count == DEPTH_X);
  assign hazard    = (useA && |hitA) || (useB && |hitB) || (useDst && queueFull);
  assign stall     = curValid && !curNop && hazard;
  assign strb.issue = curValid && !stall;
  assign inReady   = !curValid || strb.issue;
  assign strb.load = inValid && inReady;
  assign strb.push = strb.issue && useDst;
  assign popOk     = wbPop && (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) qMem[i] <= '0;
    end else begin
      if (strb.push) begin
        qMem[tail] <= dst;
        tail       <= (tail == LAST) ? '0 : tail + 1'b1;
      end
      if (popOk) head <= (head == LAST) ? '0 : head + 1'b1;
      count <= count + CNT_W'(strb.push) - CNT_W'(popOk);
    end
  end

  assign pendHead  = qMem[head];
  assign pendCount = count;

  // R7: occupancy never exceeds capacity
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= DEPTH_X);

  // R7: a lone pop removes exactly one entry
  a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (wbPop && pendCount != '0 && !strb.push) |=> (pendCount == $past(pendCount) - 1'b1));

  // R8: nothing is appended to a full queue
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == DEPTH_X) |-> !strb.push);

  // R9: a no-operation never waits
  a_r9_nop_flows: assert property (@(posedge clk) disable iff (!rstN)
    (curValid && curNop) |-> (strb.issue && !strb.push));

endmodule

// File: rtl/decodeScoreboard.sv
module decodeScoreboard
  import decodePkg::*;
#(
  parameter int WORD_W = 32,
  parameter int REG_W  = 5,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inStore,
  input  logic              inNop,
  output logic              inReady,
  output logic              stall,
  output logic              decValid,
  output logic [1:0]        decType,
  output logic              decNop,
  output logic [WORD_W-1:0] decS1,
  output logic [WORD_W-1:0] decS2,
  output logic [WORD_W-1:0] decS3,
  input  logic              wbPop,
  output logic [REG_W-1:0]  pendHead,
  output logic [$clog2(DEPTH):0] pendCount
);

  decStrobe_t       strb;
  logic             curValid, curNop;
  logic [REG_W-1:0] srcA, srcB, dst;
  logic             useA, useB, useDst;

  decodeDatapath #(.WORD_W(WORD_W), .REG_W(REG_W)) uData (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inStore(inStore), .inNop(inNop),
    .strb(strb), .curValid(curValid), .curNop(curNop),
    .srcA(srcA), .srcB(srcB), .useA(useA), .useB(useB),
    .dst(dst), .useDst(useDst), .decType(decType),
    .decS1(decS1), .decS2(decS2), .decS3(decS3)
  );

  decodeControl #(.REG_W(REG_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wbPop(wbPop),
    .curValid(curValid), .curNop(curNop),
    .srcA(srcA), .srcB(srcB), .useA(useA), .useB(useB),
    .dst(dst), .useDst(useDst), .strb(strb), .stall(stall),
    .inReady(inReady), .pendHead(pendHead), .pendCount(pendCount)
  );

  assign decValid = strb.issue;
  assign decNop   = curValid && curNop;

endmodule

// File: tb/tb_decodeScoreboard.sv
module tb_decodeScoreboard;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inStore = 1'b0;
  logic        inNop = 1'b0;
  logic        wbPop = 1'b0;
  logic        inReady, stall, decValid, decNop;
  logic [1:0]  decType;
  logic [31:0] decS1, decS2, decS3;
  logic [4:0]  pendHead;
  logic [3:0]  pendCount;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decodeScoreboard dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inStore(inStore), .inNop(inNop), .inReady(inReady), .stall(stall),
    .decValid(decValid), .decType(decType), .decNop(decNop),
    .decS1(decS1), .decS2(decS2), .decS3(decS3), .wbPop(wbPop),
    .pendHead(pendHead), .pendCount(pendCount)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        st;
    logic        nop;
    logic [1:0]  ty;
    logic [31:0] e1;
    logic [31:0] e2;
    logic [31:0] e3;
    logic        push;
    logic [4:0]  dest;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{ {15'd0, 5'd7, 5'd2, 5'd1, 2'b00}, 1'b0, 1'b0, 2'd0, 32'd1, 32'd2, 32'd7, 1'b1, 5'd7 },
    '{ {20'hFFFFB, 5'd9, 5'd4, 2'b01}, 1'b0, 1'b0, 2'd1, 32'd4, 32'd9, 32'hFFFFFFFB, 1'b1, 5'd9 },
    '{ {20'h00010, 5'd6, 5'd5, 2'b01}, 1'b1, 1'b0, 2'd1, 32'd5, 32'd6, 32'd16, 1'b0, 5'd0 },
    '{ {25'h0000040, 5'd3, 2'b10}, 1'b0, 1'b0, 2'd2, 32'd3, 32'd64, 32'd0, 1'b0, 5'd0 },
    '{ {25'h1FFFFFF, 5'd0, 2'b10}, 1'b0, 1'b0, 2'd2, 32'd0, 32'hFFFFFFFF, 32'd0, 1'b0, 5'd0 },
    '{ {30'h2AAAAAAA, 2'b11}, 1'b0, 1'b0, 2'd3, 32'd0, 32'd0, 32'd0, 1'b0, 5'd0 },
    '{ {15'd0, 5'd8, 5'd8, 5'd8, 2'b00}, 1'b0, 1'b1, 2'd0, 32'd0, 32'd0, 32'd0, 1'b0, 5'd0 },
    '{ {15'h5555, 5'd31, 5'd30, 5'd29, 2'b00}, 1'b0, 1'b0, 2'd0, 32'd29, 32'd30, 32'd31, 1'b1, 5'd31 }
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic present(input logic [31:0] w, input logic st, input logic np);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    inStore = st;
    inNop   = np;
    @(negedge clk);
    inValid = 1'b0;
    inStore = 1'b0;
    inNop   = 1'b0;
  endtask

  task automatic popOne();
    @(negedge clk);
    wbPop = 1'b1;
    @(negedge clk);
    wbPop = 1'b0;
  endtask

  function automatic logic [31:0] immWord(input logic [4:0] a, input logic [4:0] b);
    return {20'h00001, b, a, 2'b01};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(pendCount == 0, "R10", "pendCount", 32'(pendCount), 0);
    check(!stall && !decValid, "R10", "stall/decValid", {stall, decValid}, 0);
    check(inReady == 1, "R10", "inReady", 32'(inReady), 1);

    // Table walk with an empty queue
    for (int v = 0; v < NV; v++) begin
      present(VECS[v].word, VECS[v].st, VECS[v].nop);
      check(stall == 0 && decValid == 1, "R11", "issue", {stall, decValid}, 1);
      check(inReady == 1, "R11", "inReady", 32'(inReady), 1);
      if (!VECS[v].nop)
        check(decType == VECS[v].ty, "R1", "decType", 32'(decType), 32'(VECS[v].ty));
      check(decNop == VECS[v].nop, "R9", "decNop", 32'(decNop), 32'(VECS[v].nop));
      check(decS1 == VECS[v].e1, "R2/R3/R5 S1", "decS1", decS1, VECS[v].e1);
      check(decS2 == VECS[v].e2, "R2/R3/R5 S2", "decS2", decS2, VECS[v].e2);
      check(decS3 == VECS[v].e3, "R2/R3/R5 S3", "decS3", decS3, VECS[v].e3);
      @(negedge clk);
      check(pendCount == 4'(VECS[v].push), "R7", "pendCount after issue",
            32'(pendCount), 32'(VECS[v].push));
      if (VECS[v].push) begin
        check(pendHead == VECS[v].dest, "R7", "pendHead", 32'(pendHead), 32'(VECS[v].dest));
        popOne();
      end
    end

    // R6: register-class read of a pending register stalls until popped
    present(immWord(5'd4, 5'd9), 1'b0, 1'b0);
    present({15'd0, 5'd7, 5'd9, 5'd1, 2'b00}, 1'b0, 1'b0);
    check(stall == 1 && decValid == 0, "R6", "stall on S2", {stall, decValid}, 2'b10);
    check(inReady == 0, "R6", "inReady while stalled", 32'(inReady), 0);
    @(negedge clk);
    check(stall == 1 && decS3 == 32'd7, "R6", "held", decS3, 32'd7);
    popOne();
    check(stall == 0 && decValid == 1, "R6", "issue after pop", {stall, decValid}, 2'b01);
    @(negedge clk);
    check(pendCount == 1 && pendHead == 5'd7, "R6", "dest queued", 32'(pendHead), 32'd7);
    popOne();

    // R4: store reads its second field
    present(immWord(5'd1, 5'd12), 1'b0, 1'b0);
    present(immWord(5'd3, 5'd12), 1'b1, 1'b0);
    check(stall == 1, "R4", "store stalls on S2", 32'(stall), 1);
    popOne();
    check(decValid == 1, "R4", "store issues", 32'(decValid), 1);
    @(negedge clk);
    check(pendCount == 0, "R4", "store reserves nothing", 32'(pendCount), 0);

    // R3: non-store S2 is not checked (same destination twice)
    present(immWord(5'd2, 5'd13), 1'b0, 1'b0);
    present(immWord(5'd3, 5'd13), 1'b0, 1'b0);
    check(stall == 0, "R3", "no check on S2", 32'(stall), 0);
    @(negedge clk);
    check(pendCount == 2, "R3", "second reserve", 32'(pendCount), 2);
    popOne();
    popOne();

    // R7: ordering, push+pop together, empty pop
    present(immWord(5'd1, 5'd10), 1'b0, 1'b0);
    present(immWord(5'd1, 5'd11), 1'b0, 1'b0);
    present(immWord(5'd1, 5'd12), 1'b0, 1'b0);
    @(negedge clk);
    check(pendCount == 3 && pendHead == 5'd10, "R7", "head oldest", 32'(pendHead), 32'd10);
    popOne();
    check(pendHead == 5'd11, "R7", "head after pop", 32'(pendHead), 32'd11);
    popOne();
    present(immWord(5'd1, 5'd14), 1'b0, 1'b0);
    wbPop = 1'b1;
    @(negedge clk);
    wbPop = 1'b0;
    check(pendCount == 1 && pendHead == 5'd14, "R7", "push with pop", 32'(pendCount), 1);
    popOne();
    popOne();
    check(pendCount == 0, "R7", "empty pop ignored", 32'(pendCount), 0);

    // R8: full queue
    for (int k = 0; k < 8; k++) present(immWord(5'd1, 5'(16 + k)), 1'b0, 1'b0);
    @(negedge clk);
    check(pendCount == 8, "R8", "full", 32'(pendCount), 8);
    present(immWord(5'd1, 5'd24), 1'b0, 1'b0);
    check(stall == 1, "R8", "reserve stalls when full", 32'(stall), 1);
    popOne();
    check(decValid == 1, "R8", "issue after pop", 32'(decValid), 1);
    @(negedge clk);
    check(pendCount == 8 && pendHead == 5'd17, "R8", "refilled", 32'(pendHead), 32'd17);
    present({25'h0000010, 5'd2, 2'b10}, 1'b0, 1'b0);
    check(stall == 0 && decValid == 1, "R8", "jump issues while full", {stall, decValid}, 1);
    for (int k = 0; k < 8; k++) popOne();

    // R9: no-operation ignores pending registers
    present(immWord(5'd1, 5'd5), 1'b0, 1'b0);
    present({15'd0, 5'd5, 5'd5, 5'd5, 2'b00}, 1'b0, 1'b1);
    check(stall == 0 && decValid == 1 && decNop == 1, "R9", "nop flows",
          {stall, decValid, decNop}, 3'b011);
    check(decS1 == 0 && decS2 == 0, "R9", "nop fields", decS1 | decS2, 0);
    @(negedge clk);
    check(pendCount == 1, "R9", "nop reserves nothing", 32'(pendCount), 1);

    // R1: invalid class ignores pending registers and reserves nothing
    present({30'h00000005, 2'b11}, 1'b0, 1'b0);
    check(stall == 0 && decS1 == 0, "R1", "invalid flows", decS1, 0);
    @(negedge clk);
    check(pendCount == 1, "R1", "invalid reserves nothing", 32'(pendCount), 1);
    popOne();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule